// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the write port of a parallel flash-style memory and turns sequences of bus writes into operation requests. Every command starts with two fixed unlock writes. A third write carries a command byte. Two of the command bytes are setup codes, and each of those needs a second unlock pair and a sixth write that names the final operation. When a sequence completes and the current context allows that command, the decoder raises a one-clock request toward the embedded program/erase controller. It also steers the read path to the memory array, the identifier codes or the status word.

The controller reports its state back through two plain flags: `busy` and `suspended`. The decoder remembers whether the last operation it launched was an erase, so it can tell a busy erase from a busy program or protect operation. It narrows the accepted command set to match each of these contexts. All pins are plain control and data pins. There is no stream interface, so no back-pressure applies. The write strobe is expected to be synchronous to `clk` and to stay low and then high for at least one clock each.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every request output is 0, `read_sel` is 0 (array), `word_mode` is 1 and `sector_addr` is 0.
- R2: A sequence opens with data AAh at address 5555h and then 55h at 2AAAh. Only address bits 14:0 are compared. The address and the mode pin are captured on the clock in which a low `we_n` is first seen. The data is taken on the clock in which `we_n` is first seen high again.
- R3: With the controller idle, the third-write codes act as follows.
  - F0h sets `read_sel` to 0 (array).
  - 90h sets `read_sel` to 1 (identifier).
  - 70h sets `read_sel` to 2 (status).
  - A0h pulses `req_program` and selects status.
  - 50h pulses `req_clear_status`.
  - C0h pulses `req_sleep`.
  - Neither 50h nor C0h changes `read_sel`.
- R4: 80h followed by AAh@5555h, 55h@2AAAh and a sixth write selects an erase. A sixth write of 10h at 5555h pulses `req_chip_erase`. A sixth write of 30h at any address pulses `req_sector_erase` and loads `sector_addr` from address bits 19:16. Either erase selects status.
- R5: 60h followed by the same unlock pair selects protect setup. A sixth write of 20h pulses `req_sector_lock` and 40h pulses `req_sector_unlock`, but only when address bits 19:16 are 0000b or 1111b. For any other sector there is no request and `read_sel` and `sector_addr` keep their values.
- R6: A write that does not match the expected step, or an unknown command byte, returns the tracker to idle with no output change. A complete sequence issued afterwards works normally.
- R7: A request is high for exactly one clock. It starts on the first clock after the final write's rising strobe edge. At most one request is high at a time.
- R8: While `busy` is high, `suspended` is low and the last launched operation was a program, lock or unlock, only 70h is honoured.
- R9: While `busy` is high, `suspended` is low and the last launched operation was an erase, only 70h and B0h are honoured. B0h pulses `req_suspend` and selects status.
- R10: While `suspended` is high, only four commands are honoured.
  - F0h selects the array.
  - 70h selects status.
  - E0h pulses `req_abort` and selects status.
  - D0h pulses `req_resume` and selects status.
  - D0h and E0h are ignored in every other context, and B0h is honoured only as in R9.
- R11: `word_mode` takes the value of `mode_word` captured during the third write of a sequence whose third step is accepted. The mode pin during any other write has no effect.
- R12: `read_sel` changes only when an accepted command sets it. Otherwise, including across rejected or broken sequences, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (20) | Bus address, captured when the strobe falls |
| bus_data | input | 8 | Command/data byte, taken when the strobe rises |
| we_n | input | 1 | Active-low write strobe, synchronous to clk |
| mode_word | input | 1 | 1 = 16-bit word bus, 0 = byte bus |
| busy | input | 1 | Controller is running an operation |
| suspended | input | 1 | Controller has an erase suspended |
| req_program | output | 1 | Page program start pulse |
| req_chip_erase | output | 1 | Chip erase start pulse |
| req_sector_erase | output | 1 | Sector erase start pulse |
| req_sector_lock | output | 1 | Sector lock start pulse |
| req_sector_unlock | output | 1 | Sector unlock start pulse |
| req_suspend | output | 1 | Erase suspend pulse |
| req_resume | output | 1 | Erase resume pulse |
| req_sleep | output | 1 | Sleep entry pulse |
| req_abort | output | 1 | Abort pulse |
| req_clear_status | output | 1 | Clear status pulse |
| sector_addr | output | SECT_W (4) | Sector of the last accepted sector command |
| word_mode | output | 1 | Bus width sampled at the last accepted third write |
| read_sel | output | 2 | 0 array, 1 identifier, 2 status |

## Verification
The hardest situations to reach are the restricted contexts: a busy erase, a busy program and a suspended erase. The decoder's own memory of the last launched operation decides among them, so a given `busy` level means different things depending on history. The stimulus launches an erase or a program first and then drives `busy` and `suspended` to match. A bench model tracks the same history, so that in random runs the flags are set freely while the expected outcome still follows the requirements. Sequences are also broken at a random step to reach every tracker state before the mismatch.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_SETUP,
    SQ_UNL4,
    SQ_UNL5
  } seq_st_e;

  typedef struct packed {
    logic prog;
    logic chip_erase;
    logic sect_erase;
    logic lock;
    logic unlock;
    logic suspend;
    logic resume;
    logic sleep;
    logic abort_op;
    logic clr_stat;
  } op_req_t;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OP_RD_ARRAY = 8'hF0;
  localparam logic [7:0] OP_RD_IDENT = 8'h90;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_RESUME   = 8'hD0;
  localparam logic [7:0] OP_RD_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_SLEEP    = 8'hC0;
  localparam logic [7:0] OP_ABORT    = 8'hE0;
  localparam logic [7:0] OP_ERASE_SU = 8'h80;
  localparam logic [7:0] OP_PROT_SU  = 8'h60;
  localparam logic [7:0] FIN_CHIP    = 8'h10;
  localparam logic [7:0] FIN_SECTOR  = 8'h30;
  localparam logic [7:0] FIN_LOCK    = 8'h20;
  localparam logic [7:0] FIN_UNLOCK  = 8'h40;

endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic              mode_word,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_rise,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_word
);
  logic we_q;
  logic wr_fall;

  assign wr_fall = we_q & ~we_n;
  assign wr_rise = ~we_q & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      lat_addr <= '0;
      lat_word <= 1'b1;
    end else begin
      we_q <= we_n;
      if (wr_fall) begin
        lat_addr <= bus_addr;
        lat_word <= mode_word;
      end
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fall |=> $stable(lat_addr)); // R2

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rise,
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       wr_data,
  input  logic             setup_ok,
  output logic             evt3,
  output logic             evt6,
  output logic             prot_kind
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(15'h5555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(15'h2AAA);

  seq_st_e st, st_nx;
  logic    kind_nx;
  logic    key1_hit, key2_hit;

  assign key1_hit = (wr_data == KEY_FIRST)  && (cmp_addr == ADR_A);
  assign key2_hit = (wr_data == KEY_SECOND) && (cmp_addr == ADR_B);
  assign evt3 = wr_rise && (st == SQ_UNL2);
  assign evt6 = wr_rise && (st == SQ_UNL5);

  always_comb begin
    st_nx   = st;
    kind_nx = prot_kind;
    if (wr_rise) begin
      st_nx = SQ_IDLE;
      case (st)
        SQ_IDLE:  if (key1_hit) st_nx = SQ_UNL1;
        SQ_UNL1:  if (key2_hit) st_nx = SQ_UNL2;
        SQ_UNL2: begin
          if (setup_ok && (wr_data == OP_ERASE_SU || wr_data == OP_PROT_SU)) begin
            st_nx   = SQ_SETUP;
            kind_nx = (wr_data == OP_PROT_SU);
          end
        end
        SQ_SETUP: if (key1_hit) st_nx = SQ_UNL4;
        SQ_UNL4:  if (key2_hit) st_nx = SQ_UNL5;
        default:  st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      prot_kind <= 1'b0;
    end else begin
      st        <= st_nx;
      prot_kind <= kind_nx;
    end
  end

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> $stable(st)); // R6
  AST_UNL2_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_UNL2 && $past(st) != SQ_UNL2) |-> $past(st) == SQ_UNL1); // R2

endmodule

// File: rtl/fcd_gate.sv
module fcd_gate
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W  = 15,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt3,
  input  logic              evt6,
  input  logic              prot_kind,
  input  logic [7:0]        wr_data,
  input  logic [CMP_W-1:0]  cmp_addr,
  input  logic [SECT_W-1:0] sect_in,
  input  logic              lat_word,
  input  logic              busy,
  input  logic              suspended,
  output logic              setup_ok,
  output op_req_t           req,
  output rd_sel_e           read_sel,
  output logic              word_mode,
  output logic [SECT_W-1:0] sector_addr
);
  localparam logic [CMP_W-1:0]  ADR_A    = CMP_W'(15'h5555);
  localparam logic [SECT_W-1:0] SECT_TOP = '1;
  localparam logic [SECT_W-1:0] SECT_BOT = '0;

  logic              erase_op;
  logic              idle_c, prog_busy, er_busy;
  logic              acc3;
  op_req_t           req_nx;
  rd_sel_e           rsel_nx;
  logic [SECT_W-1:0] sect_nx;
  logic              sect_edge_ok;

  assign idle_c       = !busy && !suspended;
  assign prog_busy    = busy && !suspended && !erase_op;
  assign er_busy      = busy && !suspended && erase_op;
  assign setup_ok     = idle_c;
  assign sect_edge_ok = (sect_in == SECT_TOP) || (sect_in == SECT_BOT);

  always_comb begin
    req_nx  = '0;
    rsel_nx = read_sel;
    sect_nx = sector_addr;
    acc3    = 1'b0;
    if (evt3) begin
      case (wr_data)
        OP_RD_ARRAY: if (idle_c || suspended) begin acc3 = 1'b1; rsel_nx = RD_ARRAY; end
        OP_RD_IDENT: if (idle_c) begin acc3 = 1'b1; rsel_nx = RD_IDENT; end
        OP_RD_STAT:  begin acc3 = 1'b1; rsel_nx = RD_STATUS; end
        OP_PROGRAM:  if (idle_c) begin acc3 = 1'b1; req_nx.prog = 1'b1; rsel_nx = RD_STATUS; end
        OP_SUSPEND:  if (er_busy) begin acc3 = 1'b1; req_nx.suspend = 1'b1; rsel_nx = RD_STATUS; end
        OP_RESUME:   if (suspended) begin acc3 = 1'b1; req_nx.resume = 1'b1; rsel_nx = RD_STATUS; end
        OP_ABORT:    if (suspended) begin acc3 = 1'b1; req_nx.abort_op = 1'b1; rsel_nx = RD_STATUS; end
        OP_CLR_STAT: if (idle_c) begin acc3 = 1'b1; req_nx.clr_stat = 1'b1; end
        OP_SLEEP:    if (idle_c) begin acc3 = 1'b1; req_nx.sleep = 1'b1; end
        OP_ERASE_SU, OP_PROT_SU: if (idle_c) acc3 = 1'b1;
        default: ;
      endcase
    end
    if (evt6 && idle_c) begin
      if (!prot_kind) begin
        if (wr_data == FIN_CHIP && cmp_addr == ADR_A) begin
          req_nx.chip_erase = 1'b1;
          rsel_nx = RD_STATUS;
        end else if (wr_data == FIN_SECTOR) begin
          req_nx.sect_erase = 1'b1;
          rsel_nx = RD_STATUS;
          sect_nx = sect_in;
        end
      end else if (sect_edge_ok) begin
        if (wr_data == FIN_LOCK) begin
          req_nx.lock = 1'b1;
          rsel_nx = RD_STATUS;
          sect_nx = sect_in;
        end else if (wr_data == FIN_UNLOCK) begin
          req_nx.unlock = 1'b1;
          rsel_nx = RD_STATUS;
          sect_nx = sect_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req         <= '0;
      read_sel    <= RD_ARRAY;
      word_mode   <= 1'b1;
      sector_addr <= '0;
      erase_op    <= 1'b0;
    end else begin
      req         <= req_nx;
      read_sel    <= rsel_nx;
      sector_addr <= sect_nx;
      if (acc3) word_mode <= lat_word;
      if (req_nx.chip_erase || req_nx.sect_erase) erase_op <= 1'b1;
      else if (req_nx.prog || req_nx.lock || req_nx.unlock) erase_op <= 1'b0;
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req)); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> !(|req)); // R7
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(suspended) && !$past(erase_op)) |-> !(|req)); // R8
  AST_ERASE_SUSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(suspended) && $past(erase_op) && (|req)) |-> req.suspend); // R9
  AST_SUSP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(suspended) && (|req)) |-> (req.resume || req.abort_op)); // R10
  AST_PROT_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (req.lock || req.unlock) |-> (sector_addr == SECT_TOP || sector_addr == SECT_BOT)); // R5
  AST_OP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req.prog || req.chip_erase || req.sect_erase || req.lock || req.unlock)
      |-> read_sel == RD_STATUS); // R12

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CMP_W  = 15,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              we_n,
  input  logic              mode_word,
  input  logic              busy,
  input  logic              suspended,
  output logic              req_program,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic              req_sector_lock,
  output logic              req_sector_unlock,
  output logic              req_suspend,
  output logic              req_resume,
  output logic              req_sleep,
  output logic              req_abort,
  output logic              req_clear_status,
  output logic [SECT_W-1:0] sector_addr,
  output logic              word_mode,
  output logic [1:0]        read_sel
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic              wr_rise;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_word;
  logic              evt3, evt6, prot_kind, setup_ok;
  op_req_t           req;
  rd_sel_e           rsel;

  fcd_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .mode_word(mode_word),
    .bus_addr(bus_addr), .wr_rise(wr_rise), .lat_addr(lat_addr), .lat_word(lat_word)
  );

  fcd_seq #(.CMP_W(CMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .cmp_addr(lat_addr[CMP_W-1:0]),
    .wr_data(bus_data), .setup_ok(setup_ok), .evt3(evt3), .evt6(evt6),
    .prot_kind(prot_kind)
  );

  fcd_gate #(.CMP_W(CMP_W), .SECT_W(SECT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .evt3(evt3), .evt6(evt6), .prot_kind(prot_kind),
    .wr_data(bus_data), .cmp_addr(lat_addr[CMP_W-1:0]),
    .sect_in(lat_addr[SECT_LSB +: SECT_W]), .lat_word(lat_word),
    .busy(busy), .suspended(suspended), .setup_ok(setup_ok), .req(req),
    .read_sel(rsel), .word_mode(word_mode), .sector_addr(sector_addr)
  );

  assign read_sel          = rsel;
  assign req_program       = req.prog;
  assign req_chip_erase    = req.chip_erase;
  assign req_sector_erase  = req.sect_erase;
  assign req_sector_lock   = req.lock;
  assign req_sector_unlock = req.unlock;
  assign req_suspend       = req.suspend;
  assign req_resume        = req.resume;
  assign req_sleep         = req.sleep;
  assign req_abort         = req.abort_op;
  assign req_clear_status  = req.clr_stat;

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int B_PROG = 9, B_CHIP = 8, B_SECT = 7, B_LOCK = 6, B_UNLK = 5;
  localparam int B_SUSP = 4, B_RESM = 3, B_SLEEP = 2, B_ABORT = 1, B_CLR = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic we_n = 1'b1, mode_word = 1'b1, busy = 1'b0, suspended = 1'b0;
  logic rq_p, rq_c, rq_s, rq_l, rq_u, rq_su, rq_re, rq_sl, rq_ab, rq_cl;
  logic [3:0] sector_addr;
  logic word_mode;
  logic [1:0] read_sel;
  wire [9:0] dut_req = {rq_p, rq_c, rq_s, rq_l, rq_u, rq_su, rq_re, rq_sl, rq_ab, rq_cl};

  int n_chk = 0, n_err = 0;
  logic [1:0] m_rsel = 2'd0;
  bit m_word = 1'b1, m_erase = 1'b0;
  logic [3:0] m_sect = 4'd0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data), .we_n(we_n),
    .mode_word(mode_word), .busy(busy), .suspended(suspended),
    .req_program(rq_p), .req_chip_erase(rq_c), .req_sector_erase(rq_s),
    .req_sector_lock(rq_l), .req_sector_unlock(rq_u), .req_suspend(rq_su),
    .req_resume(rq_re), .req_sleep(rq_sl), .req_abort(rq_ab), .req_clear_status(rq_cl),
    .sector_addr(sector_addr), .word_mode(word_mode), .read_sel(read_sel)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input bit mp);
    @(negedge clk);
    bus_addr = a; bus_data = d; mode_word = mp; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
  endtask

  // Expected effect of a third-cycle code in the current context (R3, R8, R9, R10)
  task automatic model3(input logic [7:0] c, output bit acc, output logic [9:0] er,
                        inout logic [1:0] rs);
    bit idle = !busy && !suspended;
    bit erb  = busy && !suspended && m_erase;
    acc = 1'b0; er = '0;
    case (c)
      8'hF0: if (idle || suspended) begin acc = 1; rs = 2'd0; end
      8'h90: if (idle) begin acc = 1; rs = 2'd1; end
      8'h70: begin acc = 1; rs = 2'd2; end
      8'hA0: if (idle) begin acc = 1; er[B_PROG] = 1; rs = 2'd2; end
      8'hB0: if (erb) begin acc = 1; er[B_SUSP] = 1; rs = 2'd2; end
      8'hD0: if (suspended) begin acc = 1; er[B_RESM] = 1; rs = 2'd2; end
      8'hE0: if (suspended) begin acc = 1; er[B_ABORT] = 1; rs = 2'd2; end
      8'h50: if (idle) begin acc = 1; er[B_CLR] = 1; end
      8'hC0: if (idle) begin acc = 1; er[B_SLEEP] = 1; end
      8'h80, 8'h60: if (idle) acc = 1;
      default: ;
    endcase
  endtask

  task automatic run_cmd(input logic [7:0] c3, input logic [7:0] c6, input logic [19:0] a6,
                         input bit mw, input int brk, input string tag);
    bit six = (c3 == 8'h80) || (c3 == 8'h60);
    int n = six ? 6 : 3;
    bit stop = 1'b0;
    bit acc;
    logic [9:0] e_req = '0;
    logic [9:0] r3;
    logic [1:0] e_rsel = m_rsel;
    bit e_word = m_word, e_erase = m_erase;
    logic [3:0] e_sect = m_sect;
    for (int i = 1; i <= n && !stop; i++) begin
      logic [19:0] a;
      logic [7:0] d;
      a = {5'($urandom()), 15'h5555};
      d = 8'hAA;
      if (i == 2 || i == 5) begin a = {5'($urandom()), 15'h2AAA}; d = 8'h55; end
      if (i == 3) d = c3;
      if (i == 6) begin a = a6; d = c6; end
      if (i == brk) begin
        if (i == 3 || i == 6) d = d ^ 8'h01; else a = a ^ 20'h8;
        stop = 1'b1;
      end
      wr(a, d, (i == 3) ? mw : !mw);
      if (i == 3 && !stop) begin
        model3(c3, acc, r3, e_rsel);
        e_req = r3;
        if (acc) e_word = mw;
        if (r3[B_PROG]) e_erase = 1'b0;
        if (six && !acc) stop = 1'b1;
      end
      if (i == 6 && !stop) begin
        if (c3 == 8'h80) begin
          if (c6 == 8'h10 && a6[14:0] == 15'h5555) begin e_req[B_CHIP] = 1; e_rsel = 2'd2; e_erase = 1; end
          else if (c6 == 8'h30) begin e_req[B_SECT] = 1; e_rsel = 2'd2; e_erase = 1; e_sect = a6[19:16]; end
        end else if (a6[19:16] == 4'h0 || a6[19:16] == 4'hF) begin
          if (c6 == 8'h20) begin e_req[B_LOCK] = 1; e_rsel = 2'd2; e_erase = 0; e_sect = a6[19:16]; end
          else if (c6 == 8'h40) begin e_req[B_UNLK] = 1; e_rsel = 2'd2; e_erase = 0; e_sect = a6[19:16]; end
        end
      end
    end
    chk(dut_req == e_req, tag, "request vector", 32'(dut_req), 32'(e_req));
    chk(read_sel == e_rsel, tag, "read_sel", 32'(read_sel), 32'(e_rsel));
    chk(word_mode == e_word, tag, "word_mode", 32'(word_mode), 32'(e_word));
    chk(sector_addr == e_sect, tag, "sector_addr", 32'(sector_addr), 32'(e_sect));
    if (e_req != '0) begin
      @(negedge clk);
      chk(dut_req == '0, "R7", "pulse longer than one clock", 32'(dut_req), 32'h0);
    end
    m_rsel = e_rsel; m_word = e_word; m_erase = e_erase; m_sect = e_sect;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] codes [13];
    void'($urandom(32'd20240611));
    codes = '{8'hF0, 8'h90, 8'hA0, 8'hB0, 8'hD0, 8'h70, 8'h50, 8'hC0, 8'hE0, 8'h80, 8'h60, 8'h80, 8'h33};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dut_req == '0, "R1", "reset requests", 32'(dut_req), 0);
    chk(read_sel == 2'd0, "R1", "reset read_sel", 32'(read_sel), 0);
    chk(word_mode == 1'b1, "R1", "reset word_mode", 32'(word_mode), 1);
    chk(sector_addr == 4'd0, "R1", "reset sector", 32'(sector_addr), 0);

    run_cmd(8'h90, 8'h00, 20'h0, 1'b1, 0, "R2/R3");   // high address bits random
    run_cmd(8'hF0, 8'h00, 20'h0, 1'b1, 0, "R3");
    run_cmd(8'h90, 8'h00, 20'h0, 1'b1, 2, "R6");      // broken second unlock
    run_cmd(8'h70, 8'h00, 20'h0, 1'b1, 0, "R6");
    run_cmd(8'hF0, 8'h00, 20'h0, 1'b1, 0, "R3");
    run_cmd(8'h5A, 8'h00, 20'h0, 1'b1, 0, "R6");      // unknown code keeps array
    run_cmd(8'h80, 8'h30, 20'h91234, 1'b0, 0, "R4/R11");
    busy = 1'b1;
    run_cmd(8'hA0, 8'h00, 20'h0, 1'b1, 0, "R9");
    run_cmd(8'hB0, 8'h00, 20'h0, 1'b1, 0, "R9");
    suspended = 1'b1;
    run_cmd(8'hC0, 8'h00, 20'h0, 1'b1, 0, "R10");
    run_cmd(8'hF0, 8'h00, 20'h0, 1'b1, 0, "R10");
    run_cmd(8'hD0, 8'h00, 20'h0, 1'b1, 0, "R10");
    busy = 1'b0; suspended = 1'b0;
    run_cmd(8'hD0, 8'h00, 20'h0, 1'b1, 0, "R10");
    run_cmd(8'h80, 8'h10, 20'h35555, 1'b1, 0, "R4");
    run_cmd(8'h60, 8'h20, 20'h54321, 1'b1, 0, "R5");  // sector 5 invalid
    run_cmd(8'h60, 8'h40, 20'hF0000, 1'b1, 0, "R5");
    run_cmd(8'h60, 8'h20, 20'h00042, 1'b0, 0, "R5/R11");
    run_cmd(8'hA0, 8'h00, 20'h0, 1'b1, 0, "R3");
    busy = 1'b1;
    run_cmd(8'hB0, 8'h00, 20'h0, 1'b1, 0, "R8");
    run_cmd(8'h90, 8'h00, 20'h0, 1'b1, 0, "R8");
    run_cmd(8'h70, 8'h00, 20'h0, 1'b0, 0, "R8/R11");
    busy = 1'b0;
    run_cmd(8'hC0, 8'h00, 20'h0, 1'b1, 0, "R12");
    run_cmd(8'h50, 8'h00, 20'h0, 1'b1, 0, "R12");
    run_cmd(8'h80, 8'h30, 20'h7AAAA, 1'b1, 5, "R6/R11");
    run_cmd(8'h80, 8'h10, 20'h05555, 1'b1, 6, "R6");

    for (int k = 0; k < 400; k++) begin
      logic [7:0] c3;
      logic [7:0] c6;
      logic [19:0] a6;
      int brk;
      c3 = codes[$urandom_range(0, 12)];
      case ($urandom_range(0, 3))
        0: c6 = 8'h10;
        1: c6 = 8'h30;
        2: c6 = 8'h20;
        default: c6 = 8'h40;
      endcase
      a6 = 20'($urandom());
      if ($urandom_range(0, 1) == 1) a6[19:16] = $urandom_range(0, 1) == 1 ? 4'hF : 4'h0;
      if ($urandom_range(0, 1) == 1) a6[14:0] = 15'h5555;
      brk = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 6)) : 0;
      @(negedge clk);
      if ($urandom_range(0, 1) == 1) begin busy = 1'b0; suspended = 1'b0; end
      else begin busy = 1'b1; suspended = ($urandom_range(0, 2) == 0); end
      run_cmd(c3, c6, a6, 1'($urandom()), brk, "R3/R8/R9/R10/R12");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule